// File: doc/BRIEF.md
# Access Mode Predicting Set-Associative Cache Controller

This controller sits in front of the tag and data arrays of a four-way set-associative cache. It chooses how to probe the arrays for each lookup so that as few ways as possible are switched on. A global hit/miss predictor makes the choice before each access starts. When it expects a miss, the controller uses phased access: every tag way is read first, and at most one data way is read afterwards, and only if a tag matched. When it expects a hit, the controller uses way-predicted access: only the way that was most recently used in the addressed set is enabled, for both tag and data. Only if that guess is wrong are the other ways enabled, in a second cycle.

The controller keeps the tag store itself, with a valid bit, a tag and a most-recently-used pointer per set. It drives one tag-enable and one data-enable line per way in each cycle. When an access completes, it reports the outcome, the way that was used, and how many tag and data ways were switched on during that access. On a miss it allocates a way at once. The data transfer from the lower memory is handled outside the block.

Top module: `amp_cache_ctrl`

## Requirements
- R1: After reset, req_ready is 1, all enables and done are 0, and no entry is valid. The predictor starts at value 1, so the first access uses phased access.
- R2: The predictor is a 2-bit saturating counter. It predicts a hit when its value is 2 or more, and that prediction is latched when a request is accepted and reported on done_pred_hit. It counts up on a completed hit and down on a completed miss, saturating at 3 and 0.
- R3: In the first cycle after a request is accepted with a predicted miss, all tag enables are 1 and all data enables are 0.
- R4: If a phased access finds a tag match, the next cycle enables only the data way that matched and no tag way. done rises in that cycle, with counts of WAYS tags and 1 data way.
- R5: If a phased access finds no match, done rises in the first cycle with done_hit 0 and counts of WAYS tags and 0 data ways. No data way is enabled.
- R6: In the first cycle of a predicted-hit access, only the most recently used way of the set is enabled, for both tag and data. If that way matches, done rises in that cycle with counts of 1 and 1.
- R7: If the predicted way does not match, the next cycle enables the other WAYS-1 tag and data ways. done rises in that cycle with counts of WAYS and WAYS, and done_hit shows whether any of those ways matched.
- R8: The most recently used pointer of a set is set to the hit way on every hit and to the allocated way on every miss.
- R9: On a miss, the allocated way is the lowest-numbered invalid way of the set. If all ways are valid, it is the way after the most recently used one, modulo WAYS. The new tag then hits in that way.
- R10: req_ready is 1 only while the controller is idle. A request is accepted only when req_valid and req_ready are both 1. A request held while the controller is busy has no effect. req_ready returns the cycle after done.
- R11: When done_hit is 1, done_way gives the way that holds the tag. The address is split as req_addr[SET_W-1:0] for the set and the upper TAG_W bits for the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W (9) | Line address: tag above set |
| req_ready | output | 1 | Controller idle; request may be accepted |
| tag_en | output | WAYS (4) | Per-way tag array enable this cycle |
| data_en | output | WAYS (4) | Per-way data array enable this cycle |
| done | output | 1 | Access completes this cycle |
| done_hit | output | 1 | Outcome: 1 hit, 0 miss (allocated) |
| done_way | output | WAY_W (2) | Hit way, or allocated way on a miss |
| done_pred_hit | output | 1 | Mode used: 1 way-predicted, 0 phased |
| done_tag_cnt | output | CNT_W (3) | Tag ways enabled during the access |
| done_data_cnt | output | CNT_W (3) | Data ways enabled during the access |

## Verification
The directed part fills one set step by step, so that each of the five access paths occurs at least once: phased miss, phased hit, first-guess hit, wrong guess ending in a hit, and wrong guess ending in a miss. It also fills the set completely, which tests the allocation that follows the most recently used way. A long run of repeated hits followed by a run of new tags drives the predictor into both saturation limits. A pseudo-random stream over few tags and two sets then mixes all the paths, and requests are held during busy cycles to show that they are ignored. A behavioural model predicts the per-cycle enables, the mode, the way and the counts of every access.

// File: rtl/amp_pkg.sv
package amp_pkg;
    parameter int WAYS  = 4;
    parameter int SETS  = 8;
    parameter int TAG_W = 6;

    localparam int WAY_W  = $clog2(WAYS);
    localparam int SET_W  = $clog2(SETS);
    localparam int ADDR_W = TAG_W + SET_W;
    localparam int CNT_W  = $clog2(WAYS + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_PDATA
    } amp_state_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [SET_W-1:0] set;
    } amp_addr_t;

    function automatic logic [WAYS-1:0] way_onehot(input logic [WAY_W-1:0] idx);
        logic [WAYS-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic logic [CNT_W-1:0] count_ways(input logic [WAYS-1:0] v);
        int n;
        n = 0;
        for (int i = 0; i < WAYS; i++) n += int'(v[i]);
        return CNT_W'(n);
    endfunction

    function automatic logic [WAY_W-1:0] lowest_set(input logic [WAYS-1:0] v);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int i = WAYS - 1; i >= 0; i--) if (v[i]) r = WAY_W'(i);
        return r;
    endfunction
endpackage

// File: rtl/amp_predictor.sv
module amp_predictor (
    input  logic clk,
    input  logic rst,
    input  logic upd_en,
    input  logic upd_hit,
    output logic pred_hit
);
    logic [1:0] ctr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr <= 2'd1;
        end else if (upd_en) begin
            if (upd_hit && ctr != 2'd3)       ctr <= ctr + 2'd1;
            else if (!upd_hit && ctr != 2'd0) ctr <= ctr - 2'd1;
        end
    end

    assign pred_hit = ctr[1];
endmodule

// File: rtl/amp_tag_store.sv
module amp_tag_store
    import amp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [WAYS-1:0]  match,
    output logic [WAY_W-1:0] mru_way,
    output logic [WAY_W-1:0] victim_way,
    input  logic             upd_en,
    input  logic             upd_refill,
    input  logic [WAY_W-1:0] upd_way
);
    logic [TAG_W-1:0] tags  [SETS][WAYS];
    logic [WAYS-1:0]  valid [SETS];
    logic [WAY_W-1:0] mru   [SETS];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[lk_set][w] && (tags[lk_set][w] == lk_tag);
    end

    assign mru_way = mru[lk_set];

    always_comb begin
        if (!(&valid[lk_set]))
            victim_way = lowest_set(~valid[lk_set]);
        else if (mru[lk_set] == WAY_W'(WAYS - 1))
            victim_way = '0;
        else
            victim_way = mru[lk_set] + WAY_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid[s] <= '0;
                mru[s]   <= '0;
            end
        end else if (upd_en) begin
            mru[lk_set] <= upd_way;
            if (upd_refill) begin
                tags[lk_set][upd_way]  <= lk_tag;
                valid[lk_set][upd_way] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/amp_seq.sv
module amp_seq
    import amp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             pred_hit,
    input  logic [WAYS-1:0]  match,
    input  logic [WAY_W-1:0] mru_way,
    input  logic [WAY_W-1:0] victim_way,
    output logic             req_ready,
    output logic             accept,
    output logic [WAYS-1:0]  tag_en,
    output logic [WAYS-1:0]  data_en,
    output logic             done,
    output logic             done_hit,
    output logic [WAY_W-1:0] done_way,
    output logic             done_pred_hit,
    output logic [CNT_W-1:0] done_tag_cnt,
    output logic [CNT_W-1:0] done_data_cnt
);
    amp_state_e       state, state_nx;
    logic             mode_way;
    logic [WAY_W-1:0] hit_way_q;
    logic [CNT_W-1:0] tag_acc, data_acc;
    logic [WAYS-1:0]  pred_oh;
    logic             any_match, pred_ok;
    logic [WAY_W-1:0] match_idx;

    assign pred_oh   = way_onehot(mru_way);
    assign any_match = |match;
    assign pred_ok   = |(match & pred_oh);
    assign match_idx = lowest_set(match);
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;

    always_comb begin
        state_nx = state;
        tag_en   = '0;
        data_en  = '0;
        done     = 1'b0;
        done_hit = 1'b0;
        done_way = '0;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_FIRST;
            ST_FIRST: begin
                if (mode_way) begin
                    tag_en  = pred_oh;
                    data_en = pred_oh;
                    if (pred_ok) begin
                        done     = 1'b1;
                        done_hit = 1'b1;
                        done_way = mru_way;
                        state_nx = ST_IDLE;
                    end else begin
                        state_nx = ST_SECOND;
                    end
                end else begin
                    tag_en = '1;
                    if (any_match) begin
                        state_nx = ST_PDATA;
                    end else begin
                        done     = 1'b1;
                        done_way = victim_way;
                        state_nx = ST_IDLE;
                    end
                end
            end
            ST_SECOND: begin
                tag_en   = ~pred_oh;
                data_en  = ~pred_oh;
                done     = 1'b1;
                done_hit = any_match;
                done_way = any_match ? match_idx : victim_way;
                state_nx = ST_IDLE;
            end
            ST_PDATA: begin
                data_en  = way_onehot(hit_way_q);
                done     = 1'b1;
                done_hit = 1'b1;
                done_way = hit_way_q;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign done_pred_hit = mode_way;
    assign done_tag_cnt  = tag_acc + count_ways(tag_en);
    assign done_data_cnt = data_acc + count_ways(data_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            mode_way  <= 1'b0;
            hit_way_q <= '0;
            tag_acc   <= '0;
            data_acc  <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                mode_way <= pred_hit;
                tag_acc  <= '0;
                data_acc <= '0;
            end else begin
                tag_acc  <= done_tag_cnt;
                data_acc <= done_data_cnt;
            end
            if (state == ST_FIRST) hit_way_q <= match_idx;
        end
    end
endmodule

// File: rtl/amp_cache_ctrl.sv
module amp_cache_ctrl
    import amp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [WAYS-1:0]   tag_en,
    output logic [WAYS-1:0]   data_en,
    output logic              done,
    output logic              done_hit,
    output logic [WAY_W-1:0]  done_way,
    output logic              done_pred_hit,
    output logic [CNT_W-1:0]  done_tag_cnt,
    output logic [CNT_W-1:0]  done_data_cnt
);
    amp_addr_t        addr_q;
    logic             accept, pred_hit;
    logic [WAYS-1:0]  match;
    logic [WAY_W-1:0] mru_way, victim_way;

    always_ff @(posedge clk) begin
        if (rst)         addr_q <= '0;
        else if (accept) addr_q <= amp_addr_t'(req_addr);
    end

    amp_predictor u_pred (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (done),
        .upd_hit  (done_hit),
        .pred_hit (pred_hit)
    );

    amp_tag_store u_tags (
        .clk        (clk),
        .rst        (rst),
        .lk_set     (addr_q.set),
        .lk_tag     (addr_q.tag),
        .match      (match),
        .mru_way    (mru_way),
        .victim_way (victim_way),
        .upd_en     (done),
        .upd_refill (done && !done_hit),
        .upd_way    (done_way)
    );

    amp_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .pred_hit      (pred_hit),
        .match         (match),
        .mru_way       (mru_way),
        .victim_way    (victim_way),
        .req_ready     (req_ready),
        .accept        (accept),
        .tag_en        (tag_en),
        .data_en       (data_en),
        .done          (done),
        .done_hit      (done_hit),
        .done_way      (done_way),
        .done_pred_hit (done_pred_hit),
        .done_tag_cnt  (done_tag_cnt),
        .done_data_cnt (done_data_cnt)
    );
endmodule

// File: rtl/amp_cache_ctrl_chk.sv
module amp_cache_ctrl_chk
    import amp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [WAYS-1:0]   tag_en,
    input logic [WAYS-1:0]   data_en,
    input logic              done,
    input logic              done_hit,
    input logic              done_pred_hit,
    input logic [CNT_W-1:0]  done_tag_cnt,
    input logic [CNT_W-1:0]  done_data_cnt
);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (tag_en == '0 && data_en == '0 && !done));

    assert_done_return_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);

    assert_first_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
            ((tag_en == '1 && data_en == '0) ||
             ($countones(tag_en) == 1 && data_en == tag_en)));

    assert_phased_miss_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !done_pred_hit && !done_hit) |->
            (done_data_cnt == '0 && done_tag_cnt == CNT_W'(WAYS) && data_en == '0));

    assert_phased_hit_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !done_pred_hit && done_hit) |->
            (tag_en == '0 && $countones(data_en) == 1 && done_data_cnt == CNT_W'(1)));

    assert_wrong_guess_R7: assert property (@(posedge clk) disable iff (rst)
        (done && done_pred_hit && done_tag_cnt != CNT_W'(1)) |->
            (done_tag_cnt == CNT_W'(WAYS) && done_data_cnt == CNT_W'(WAYS)));
endmodule

bind amp_cache_ctrl amp_cache_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .tag_en        (tag_en),
    .data_en       (data_en),
    .done          (done),
    .done_hit      (done_hit),
    .done_pred_hit (done_pred_hit),
    .done_tag_cnt  (done_tag_cnt),
    .done_data_cnt (done_data_cnt)
);

// File: tb/tb_amp_cache_ctrl.sv
`timescale 1ns/1ps
module tb_amp_cache_ctrl;
    import amp_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic [WAYS-1:0]   tag_en, data_en;
    logic              done, done_hit, done_pred_hit;
    logic [WAY_W-1:0]  done_way;
    logic [CNT_W-1:0]  done_tag_cnt, done_data_cnt;

    always #2.5 clk = ~clk;

    amp_cache_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .tag_en(tag_en), .data_en(data_en), .done(done),
        .done_hit(done_hit), .done_way(done_way), .done_pred_hit(done_pred_hit),
        .done_tag_cnt(done_tag_cnt), .done_data_cnt(done_data_cnt)
    );

    int checks = 0;
    int errors = 0;

    int m_tag [SETS][WAYS];
    bit m_val [SETS][WAYS];
    int m_mru [SETS];
    int m_cnt;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ones(input int v);
        int n = 0;
        for (int i = 0; i < WAYS; i++) n += (v >> i) & 1;
        return n;
    endfunction

    // One access: starts and ends at a negedge with the controller idle.
    task automatic access(input int set, input int tg, input bit poke);
        int  mw, mru, vic, ncyc, full, exp_way, sum_t, sum_d;
        bit  pred, hit;
        int  et [2];
        int  ed [2];
        string rq [2];
        pred = (m_cnt >= 2);
        mru  = m_mru[set];
        mw   = -1;
        for (int w = 0; w < WAYS; w++) if (m_val[set][w] && m_tag[set][w] == tg) mw = w;
        vic  = -1;
        for (int w = WAYS - 1; w >= 0; w--) if (!m_val[set][w]) vic = w;
        if (vic < 0) vic = (mru + 1) % WAYS;
        full = (1 << WAYS) - 1;
        hit  = (mw >= 0);
        if (pred) begin
            et[0] = 1 << mru; ed[0] = 1 << mru; rq[0] = "R6";
            if (mw == mru) ncyc = 1;
            else begin
                ncyc = 2; et[1] = full & ~(1 << mru); ed[1] = et[1]; rq[1] = "R7";
            end
        end else begin
            et[0] = full; ed[0] = 0; rq[0] = "R3";
            if (hit) begin
                ncyc = 2; et[1] = 0; ed[1] = 1 << mw; rq[1] = "R4";
            end else begin
                ncyc = 1; rq[0] = "R5";
            end
        end
        exp_way = hit ? mw : vic;
        sum_t = 0; sum_d = 0;
        for (int c = 0; c < ncyc; c++) begin
            sum_t += ones(et[c]); sum_d += ones(ed[c]);
        end

        chk(req_ready === 1'b1, "R10", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = ADDR_W'((tg << SET_W) | set);
        @(negedge clk);
        req_valid = poke;
        req_addr  = ADDR_W'((((tg + 1) % (1 << TAG_W)) << SET_W) | set);
        for (int c = 0; c < ncyc; c++) begin
            chk(int'(tag_en) == et[c], rq[c], "tag_en", int'(tag_en), et[c]);
            chk(int'(data_en) == ed[c], rq[c], "data_en", int'(data_en), ed[c]);
            chk(done === (c == ncyc - 1), rq[c], "done", int'(done), int'(c == ncyc - 1));
            chk(req_ready === 1'b0, "R10", "ready while busy", int'(req_ready), 0);
            if (c == ncyc - 1) begin
                chk(done_pred_hit === pred, "R2", "mode", int'(done_pred_hit), int'(pred));
                chk(done_hit === hit, "R8", "outcome", int'(done_hit), int'(hit));
                chk(int'(done_way) == exp_way, hit ? "R11" : "R9", "way",
                    int'(done_way), exp_way);
                chk(int'(done_tag_cnt) == sum_t, rq[c], "tag count", int'(done_tag_cnt), sum_t);
                chk(int'(done_data_cnt) == sum_d, rq[c], "data count", int'(done_data_cnt), sum_d);
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        if (hit) begin
            m_mru[set] = mw;
            if (m_cnt < 3) m_cnt++;
        end else begin
            m_tag[set][vic] = tg; m_val[set][vic] = 1'b1; m_mru[set] = vic;
            if (m_cnt > 0) m_cnt--;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        for (int s = 0; s < SETS; s++) begin
            m_mru[s] = 0;
            for (int w = 0; w < WAYS; w++) begin m_val[s][w] = 1'b0; m_tag[s][w] = 0; end
        end
        m_cnt = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(tag_en == '0 && data_en == '0, "R1", "enables after reset",
            int'({tag_en, data_en}), 0);
        chk(done === 1'b0, "R1", "done after reset", int'(done), 0);

        // Directed: walk one set through every path
        access(0, 1, 0);   // phased miss, way 0
        access(0, 1, 0);   // phased hit
        access(0, 1, 0);   // phased hit, counter reaches 2
        access(0, 1, 0);   // first-guess hit
        access(0, 2, 1);   // wrong guess, miss, held request ignored
        access(0, 1, 0);   // wrong guess, hit in way 0
        access(0, 3, 0);   // poked tag 3 must still be absent
        access(0, 4, 0);
        access(0, 5, 0);   // full set: allocate after MRU
        access(0, 5, 0);
        for (int i = 0; i < 6; i++) access(1, 7, 0);   // saturate high
        for (int i = 0; i < 8; i++) access(2, 10 + i, 0); // saturate low
        access(2, 17, 0);

        // Mixed stream
        seed = 12345;
        for (int i = 0; i < 400; i++) begin
            seed = seed * 1103515245 + 12345;
            access((seed >> 8) & 1, ((seed >> 16) & 32'h7fff) % 6, (i % 3) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule